// File: doc/BRIEF.md
# Ethernet receive destination address filter

This block sits behind the receive MAC and decides, once per incoming frame, whether the frame is kept or thrown away. It looks at the 48-bit destination address, a flag from the MAC that marks the frame as damaged, and four control bits held in a small configuration register. From these it produces a single keep/drop verdict with a strobe.

Each address is sorted into one of three classes: broadcast, multicast or unicast. A unicast address is compared with the station address. A multicast address is looked up in a four-entry table, and each table entry carries its own valid flag. Two global drop bits, one for broadcast and one for multicast, take priority over the table and over promiscuous mode. A separate pass bit lets damaged frames through so that they are judged like good ones.

The configuration register and the table are loaded through simple single-cycle write strobes. The station address is a static input.

Top module: `rx_da_filter`

## Requirements
- R1: After reset the configuration register is all zeros (broadcast kept, multicast judged by the table, promiscuous off, damaged frames dropped), every table entry is invalid, and `dec_valid` and `dec_accept` are 0.
- R2: `dec_valid` is high exactly one clock after a cycle with `da_valid` high and low otherwise. `dec_accept` is never high while `dec_valid` is low.
- R3: An address whose 48 bits are all one is a broadcast. With `cfg_wr_data[0]` (broadcast drop) stored as 0, a broadcast is kept.
- R4: With broadcast drop stored as 1, every broadcast is dropped, even when promiscuous mode is on.
- R5: A non-broadcast address with `da_addr[40]` = 1 (bit 0 of the first octet, which is carried in `da_addr[47:40]`) is multicast. It is kept when it equals the address of a valid table entry.
- R6: A multicast address that matches no valid entry is dropped when promiscuous mode (`cfg_wr_data[2]`) is 0 and kept when it is 1.
- R7: With multicast drop (`cfg_wr_data[1]`) stored as 1, every multicast is dropped, whatever the table holds and whatever the promiscuous setting is.
- R8: A unicast address (`da_addr[40]` = 0) is kept when it equals `station_addr` or when promiscuous mode is on, and is dropped otherwise.
- R9: A frame with `frame_bad` = 1 is dropped when damaged-frame pass (`cfg_wr_data[3]`) is 0. When that bit is 1, the frame is judged by the same rules as a good frame.
- R10: A write with `tbl_wr_valid` = 0 invalidates the entry at `tbl_wr_idx`, and that entry then never matches. Each entry is written independently of the others.
- R11: A configuration write takes effect for strobes from the next cycle on. A strobe in the same cycle as the write is judged with the old settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Configuration register write strobe |
| cfg_wr_data | input | 4 | [0] broadcast drop, [1] multicast drop, [2] promiscuous, [3] damaged-frame pass |
| station_addr | input | 48 | Own unicast address |
| tbl_wr_en | input | 1 | Multicast table write strobe |
| tbl_wr_idx | input | 2 | Table entry written |
| tbl_wr_addr | input | 48 | Address stored in the entry |
| tbl_wr_valid | input | 1 | Valid flag stored in the entry |
| da_valid | input | 1 | Destination address and frame flag are present |
| da_addr | input | 48 | Destination address, first octet in [47:40] |
| frame_bad | input | 1 | MAC marks the frame as damaged |
| dec_valid | output | 1 | Verdict strobe |
| dec_accept | output | 1 | 1 = keep frame, 0 = drop |

## Verification
The hardest case to reach from the ports is a multicast address that once matched a valid entry and must stop matching after that entry is rewritten with its valid flag clear, while the stored address stays the same. The bench loads the table and shows a hit. It then clears only the valid flag of that entry, sends the same address again and expects a drop, and finally restores the entry. A strobe sent in the same cycle as a configuration write covers the ordering in R11. Vectors that set the global drop bits together with promiscuous mode and a table hit cover the override priority.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int ADDR_W = 48;
  localparam int GROUP_BIT = 40;  // bit 0 of the first octet on the wire
  localparam int CFG_W = 4;

  typedef logic [ADDR_W-1:0] mac_addr_t;

  typedef enum logic [1:0] {
    DA_UCAST = 2'd0,
    DA_MCAST = 2'd1,
    DA_BCAST = 2'd2
  } da_class_e;

  typedef struct packed {
    logic bad_pass;
    logic promisc;
    logic mcast_drop;
    logic bcast_drop;
  } rx_cfg_t;
endpackage

// File: rtl/rxf_classify.sv
module rxf_classify
  import rxf_pkg::*;
(
  input  mac_addr_t da_addr,
  input  mac_addr_t station_addr,
  output da_class_e da_class,
  output logic      uc_hit
);
  always_comb begin
    if (&da_addr)
      da_class = DA_BCAST;
    else if (da_addr[GROUP_BIT])
      da_class = DA_MCAST;
    else
      da_class = DA_UCAST;
  end

  assign uc_hit = (da_addr == station_addr);
endmodule

// File: rtl/rxf_mcast_table.sv
module rxf_mcast_table
  import rxf_pkg::*;
#(
  parameter int ENTRIES = 4,
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  mac_addr_t        wr_addr,
  input  logic             wr_valid,
  input  mac_addr_t        lookup,
  output logic             any_hit
);
  mac_addr_t          ent_addr [ENTRIES];
  logic [ENTRIES-1:0] ent_vld;
  logic [ENTRIES-1:0] hit_vec;

  always_ff @(posedge clk) begin
    if (wr_en) ent_addr[wr_idx] <= wr_addr;
  end

  always_ff @(posedge clk) begin
    if (rst)        ent_vld <= '0;
    else if (wr_en) ent_vld[wr_idx] <= wr_valid;
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hit_vec[g] = ent_vld[g] && (ent_addr[g] == lookup);
  end

  assign any_hit = |hit_vec;

  // R10: an entry written invalid cannot produce a hit afterwards
  p_cleared_entry_r10: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_valid) |=> !hit_vec[$past(wr_idx)]);
endmodule

// File: rtl/rxf_decide.sv
module rxf_decide
  import rxf_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_wr_en,
  input  logic [CFG_W-1:0] cfg_wr_data,
  input  logic             da_valid,
  input  da_class_e        da_class,
  input  logic             uc_hit,
  input  logic             mc_hit,
  input  logic             frame_bad,
  output logic             dec_valid,
  output logic             dec_accept
);
  rx_cfg_t cfg_q;
  logic    verdict;

  always_ff @(posedge clk) begin
    if (rst)            cfg_q <= '0;
    else if (cfg_wr_en) cfg_q <= rx_cfg_t'(cfg_wr_data);
  end

  always_comb begin
    if (frame_bad && !cfg_q.bad_pass)
      verdict = 1'b0;
    else begin
      unique case (da_class)
        DA_BCAST: verdict = !cfg_q.bcast_drop;
        DA_MCAST: verdict = !cfg_q.mcast_drop && (mc_hit || cfg_q.promisc);
        default:  verdict = uc_hit || cfg_q.promisc;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dec_valid  <= 1'b0;
      dec_accept <= 1'b0;
    end else begin
      dec_valid  <= da_valid;
      dec_accept <= da_valid && verdict;
    end
  end

  p_strobe_lag_r2: assert property (@(posedge clk) disable iff (rst)
    da_valid |=> dec_valid);
  p_no_spurious_r2: assert property (@(posedge clk) disable iff (rst)
    !da_valid |=> !dec_valid);
  p_accept_gated_r2: assert property (@(posedge clk) disable iff (rst)
    !dec_valid |-> !dec_accept);
  p_bcast_drop_r4: assert property (@(posedge clk) disable iff (rst)
    (da_valid && da_class == DA_BCAST && cfg_q.bcast_drop) |=> !dec_accept);
  p_mcast_drop_r7: assert property (@(posedge clk) disable iff (rst)
    (da_valid && da_class == DA_MCAST && cfg_q.mcast_drop) |=> !dec_accept);
  p_bad_drop_r9: assert property (@(posedge clk) disable iff (rst)
    (da_valid && frame_bad && !cfg_q.bad_pass) |=> !dec_accept);
endmodule

// File: rtl/rx_da_filter.sv
module rx_da_filter
  import rxf_pkg::*;
#(
  parameter int MC_ENTRIES = 4,
  localparam int MC_IDX_W = (MC_ENTRIES > 1) ? $clog2(MC_ENTRIES) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cfg_wr_en,
  input  logic [CFG_W-1:0]    cfg_wr_data,
  input  logic [ADDR_W-1:0]   station_addr,
  input  logic                tbl_wr_en,
  input  logic [MC_IDX_W-1:0] tbl_wr_idx,
  input  logic [ADDR_W-1:0]   tbl_wr_addr,
  input  logic                tbl_wr_valid,
  input  logic                da_valid,
  input  logic [ADDR_W-1:0]   da_addr,
  input  logic                frame_bad,
  output logic                dec_valid,
  output logic                dec_accept
);
  da_class_e cls;
  logic      uc_hit;
  logic      mc_hit;

  rxf_classify u_classify (
    .da_addr      (da_addr),
    .station_addr (station_addr),
    .da_class     (cls),
    .uc_hit       (uc_hit)
  );

  rxf_mcast_table #(.ENTRIES(MC_ENTRIES)) u_table (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (tbl_wr_en),
    .wr_idx   (tbl_wr_idx),
    .wr_addr  (tbl_wr_addr),
    .wr_valid (tbl_wr_valid),
    .lookup   (da_addr),
    .any_hit  (mc_hit)
  );

  rxf_decide u_decide (
    .clk         (clk),
    .rst         (rst),
    .cfg_wr_en   (cfg_wr_en),
    .cfg_wr_data (cfg_wr_data),
    .da_valid    (da_valid),
    .da_class    (cls),
    .uc_hit      (uc_hit),
    .mc_hit      (mc_hit),
    .frame_bad   (frame_bad),
    .dec_valid   (dec_valid),
    .dec_accept  (dec_accept)
  );
endmodule

// File: tb/rx_da_filter_tb.sv
module rx_da_filter_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wr_en = 1'b0;
  logic [3:0]  cfg_wr_data = '0;
  logic [47:0] station_addr = 48'h02_11_22_33_44_55;
  logic        tbl_wr_en = 1'b0;
  logic [1:0]  tbl_wr_idx = '0;
  logic [47:0] tbl_wr_addr = '0;
  logic        tbl_wr_valid = 1'b0;
  logic        da_valid = 1'b0;
  logic [47:0] da_addr = '0;
  logic        frame_bad = 1'b0;
  logic        dec_valid;
  logic        dec_accept;

  int tests = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  rx_da_filter u_dut (
    .clk(clk), .rst(rst), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
    .station_addr(station_addr), .tbl_wr_en(tbl_wr_en), .tbl_wr_idx(tbl_wr_idx),
    .tbl_wr_addr(tbl_wr_addr), .tbl_wr_valid(tbl_wr_valid), .da_valid(da_valid),
    .da_addr(da_addr), .frame_bad(frame_bad), .dec_valid(dec_valid),
    .dec_accept(dec_accept)
  );

  localparam logic [47:0] BC  = 48'hFFFF_FFFF_FFFF;
  localparam logic [47:0] MC0 = 48'h01_00_5E_00_00_01;
  localparam logic [47:0] MC1 = 48'h01_00_5E_00_00_02;
  localparam logic [47:0] MC2 = 48'h33_33_00_00_00_01;
  localparam logic [47:0] MC3 = 48'h01_80_C2_00_00_0E;
  localparam logic [47:0] MCX = 48'h01_00_5E_00_00_09;
  localparam logic [47:0] STA = 48'h02_11_22_33_44_55;
  localparam logic [47:0] UCX = 48'h02_11_22_33_44_56;

  // {cfg[3:0], da[47:0], bad, expected}
  localparam int NV = 17;
  localparam logic [53:0] VEC [NV] = '{
    {4'h0, BC,  1'b0, 1'b1},
    {4'h1, BC,  1'b0, 1'b0},
    {4'h5, BC,  1'b0, 1'b0},
    {4'h0, MC0, 1'b0, 1'b1},
    {4'h0, MC2, 1'b0, 1'b1},
    {4'h0, MCX, 1'b0, 1'b0},
    {4'h4, MCX, 1'b0, 1'b1},
    {4'h2, MC0, 1'b0, 1'b0},
    {4'h6, MCX, 1'b0, 1'b0},
    {4'h0, MC3, 1'b0, 1'b0},
    {4'h0, STA, 1'b0, 1'b1},
    {4'h0, UCX, 1'b0, 1'b0},
    {4'h4, UCX, 1'b0, 1'b1},
    {4'h0, STA, 1'b1, 1'b0},
    {4'h8, STA, 1'b1, 1'b1},
    {4'h8, UCX, 1'b1, 1'b0},
    {4'h4, BC,  1'b1, 1'b0}
  };
  localparam string VREQ [NV] = '{
    "R3", "R4", "R4", "R5", "R5", "R6", "R6", "R7", "R7", "R10",
    "R8", "R8", "R8", "R9", "R9", "R9", "R9"
  };

  task automatic check(input string req, input string what, input logic got, input logic exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b", req, what, got, exp);
    end
  endtask

  task automatic cfg_write(input logic [3:0] v);
    @(negedge clk);
    cfg_wr_en = 1'b1;
    cfg_wr_data = v;
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  task automatic tbl_write(input logic [1:0] idx, input logic [47:0] a, input logic v);
    @(negedge clk);
    tbl_wr_en = 1'b1;
    tbl_wr_idx = idx;
    tbl_wr_addr = a;
    tbl_wr_valid = v;
    @(negedge clk);
    tbl_wr_en = 1'b0;
  endtask

  task automatic send(input logic [47:0] a, input logic bad, input logic exp, input string req);
    @(negedge clk);
    da_valid = 1'b1;
    da_addr = a;
    frame_bad = bad;
    @(negedge clk);
    da_valid = 1'b0;
    frame_bad = 1'b0;
    check(req, "dec_valid", dec_valid, 1'b1);
    check(req, "dec_accept", dec_accept, exp);
  endtask

  task automatic summary;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    fails++;
    $display("FAIL R2 watchdog: actual hung expected finish");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "dec_valid in reset", dec_valid, 1'b0);
    check("R1", "dec_accept in reset", dec_accept, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    check("R2", "idle dec_valid", dec_valid, 1'b0);

    // R1: empty table, broadcast kept, damaged frame dropped
    send(MC0, 1'b0, 1'b0, "R1");
    send(BC,  1'b0, 1'b1, "R1");
    send(STA, 1'b1, 1'b0, "R1");

    tbl_write(2'd0, MC0, 1'b1);
    tbl_write(2'd1, MC1, 1'b1);
    tbl_write(2'd2, MC2, 1'b1);
    tbl_write(2'd3, MC3, 1'b0);

    for (int i = 0; i < NV; i++) begin
      cfg_write(VEC[i][53:50]);
      send(VEC[i][49:2], VEC[i][1], VEC[i][0], VREQ[i]);
    end

    // R10: clear only the valid flag of entry 1, then restore it
    cfg_write(4'h0);
    send(MC1, 1'b0, 1'b1, "R10");
    tbl_write(2'd1, MC1, 1'b0);
    send(MC1, 1'b0, 1'b0, "R10");
    send(MC0, 1'b0, 1'b1, "R10");
    tbl_write(2'd1, MC1, 1'b1);
    send(MC1, 1'b0, 1'b1, "R10");

    // R11: strobe in the same cycle as a write sees the old settings
    @(negedge clk);
    cfg_wr_en = 1'b1;
    cfg_wr_data = 4'h1;
    da_valid = 1'b1;
    da_addr = BC;
    @(negedge clk);
    cfg_wr_en = 1'b0;
    da_valid = 1'b0;
    check("R11", "same-cycle accept", dec_accept, 1'b1);
    @(negedge clk);
    check("R2", "strobe drops", dec_valid, 1'b0);
    check("R2", "accept drops", dec_accept, 1'b0);
    send(BC, 1'b0, 1'b0, "R11");

    summary();
    $finish;
  end
endmodule